// File: doc/BRIEF.md
# Zero-Flagging Hex Number Formatter

This block turns a binary value into readable hexadecimal ASCII text and sends it out one byte at a time on a valid/ready stream. A caller loads a value with a one-cycle start strobe. The block then streams the characters, most significant first, and pulses a done flag once the final character has been taken.

The formatting makes a memory dump easy to scan by eye. A value of zero is printed as a lone `0`. Any other value is printed as `0x` followed by its digits, with the leading zero nibbles dropped. To print a narrower quantity, the caller zero-extends it onto the input. The same rule also applies inside the block: the input width is a parameter, and any width below 32 gives the same text as the zero-extended 32-bit value.

Top module: `hexfmt_stream`

## Requirements
- R1: An input of zero produces exactly one character, `0` (0x30), with no prefix, followed by done.
- R2: A non-zero input first produces the two prefix characters `0` (0x30) and `x` (0x78), in that order.
- R3: After the prefix, digits begin at the most significant non-zero nibble. Every nibble from there down to nibble 0 is then sent, zeros inside the number included.
- R4: A nibble value d in 0..9 is sent as 0x30+d. A value in 10..15 is sent as the uppercase letter 0x41+(d-10).
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o is unchanged on the next cycle. One character is accepted per cycle in which both are high.
- R6: A start strobe that arrives while busy_o is high is ignored. The conversion in flight produces the same text it would have produced without it, and no second conversion follows.
- R7: done_o is high for exactly one cycle: the cycle after the last character is accepted. It is never high at any other time.
- R8: During and straight after reset, out_valid_o, busy_o and done_o are low.
- R9: A start strobe taken while idle makes out_valid_o high on the next cycle.
- R10: The input width VAL_W is a parameter and must be a multiple of 4 from 4 to 32; other values are rejected at elaboration. A VAL_W-bit input is printed exactly as its zero extension to 32 bits would be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load value_i and begin a conversion (taken only when idle) |
| value_i | input | VAL_W | Value to format |
| busy_o | output | 1 | A conversion is in progress |
| out_valid_o | output | 1 | out_data_o holds a character |
| out_ready_i | input | 1 | Sink accepts the character this cycle |
| out_data_o | output | 8 | ASCII character |
| done_o | output | 1 | One-cycle pulse after the last character is accepted |

## Verification
The bench builds two instances. The first uses the default 32-bit width and is driven with a directed set of values: zero, all ones, the top bit alone, interior-zero patterns and a walking one across all 32 positions. These cover every possible start position of the leading digit. The second is built with VAL_W = 12, which makes all 4096 inputs a short enough run to sweep exhaustively. That sweep reaches every digit value at every nibble position, and every count of suppressed leading zeros. Throughout both runs, the sink's ready signal follows a pseudo-random pattern, so stalls land on prefix, digit and final characters alike.

// File: rtl/hexfmt_pkg.sv
package hexfmt_pkg;

   typedef enum logic [2:0] {
      FMT_IDLE  = 3'd0,
      FMT_ZERO  = 3'd1,
      FMT_PFX0  = 3'd2,
      FMT_PFX1  = 3'd3,
      FMT_DIGIT = 3'd4
   } fmt_state_e;

   localparam logic [7:0] ASC_ZERO = 8'h30;
   localparam logic [7:0] ASC_X    = 8'h78;

endpackage

// File: rtl/hexfmt_lead_find.sv
module hexfmt_lead_find #(
   parameter int NIB   = 8,
   parameter int IDX_W = 3
) (
   input  logic [NIB*4-1:0] value_i,
   output logic [IDX_W-1:0] lead_o,
   output logic             nonzero_o
);

   logic [NIB-1:0] nib_nz;

   for (genvar g = 0; g < NIB; g++) begin : g_nz
      assign nib_nz[g] = |value_i[g*4 +: 4];
   end

   always_comb begin
      lead_o = '0;
      for (int k = 0; k < NIB; k++) begin
         if (nib_nz[k]) lead_o = IDX_W'(k);
      end
      nonzero_o = |nib_nz;
   end

   always_comb begin
      if (nonzero_o) begin
         assert_lead_nonzero_R3: assert (nib_nz[lead_o])
            else $error("lead nibble index points at a zero nibble");
      end
   end

endmodule

// File: rtl/hexfmt_digit_enc.sv
module hexfmt_digit_enc #(
   parameter bit UPPER_HEX = 1'b1
) (
   input  logic [3:0] nib_i,
   output logic [7:0] ascii_o
);

   logic is_dec;
   assign is_dec = (nib_i < 4'd10);

   if (UPPER_HEX) begin : g_upper
      assign ascii_o = is_dec ? (8'h30 + {4'h0, nib_i}) : (8'h37 + {4'h0, nib_i});
   end else begin : g_lower
      assign ascii_o = is_dec ? (8'h30 + {4'h0, nib_i}) : (8'h57 + {4'h0, nib_i});
   end

   always_comb begin
      if (UPPER_HEX) begin
         assert_ascii_range_R4: assert ((ascii_o >= 8'h30 && ascii_o <= 8'h39) ||
                                        (ascii_o >= 8'h41 && ascii_o <= 8'h46))
            else $error("digit code outside the hex character set");
      end
   end

endmodule

// File: rtl/hexfmt_stream.sv
module hexfmt_stream
   import hexfmt_pkg::*;
#(
   parameter int VAL_W     = 32,
   parameter bit UPPER_HEX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VAL_W-1:0] value_i,
   output logic             busy_o,
   output logic             out_valid_o,
   input  logic             out_ready_i,
   output logic [7:0]       out_data_o,
   output logic             done_o
);

   localparam int NIB   = VAL_W / 4;
   localparam int IDX_W = (NIB > 1) ? $clog2(NIB) : 1;

   if ((VAL_W % 4) != 0 || VAL_W < 4 || VAL_W > 32) begin : g_bad_width
      $error("VAL_W must be a multiple of 4 between 4 and 32");
   end

   fmt_state_e       state_q;
   logic [VAL_W-1:0] val_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;

   logic [IDX_W-1:0] lead_idx;
   logic             lead_nz;
   logic [3:0]       nib_arr [NIB];
   logic [3:0]       cur_nib;
   logic [7:0]       digit_asc;
   logic             accept;
   logic             launch;

   hexfmt_lead_find #(
      .NIB   (NIB),
      .IDX_W (IDX_W)
   ) u_lead (
      .value_i   (value_i),
      .lead_o    (lead_idx),
      .nonzero_o (lead_nz)
   );

   for (genvar g = 0; g < NIB; g++) begin : g_nib
      assign nib_arr[g] = val_q[g*4 +: 4];
   end

   assign cur_nib = nib_arr[idx_q];

   hexfmt_digit_enc #(
      .UPPER_HEX (UPPER_HEX)
   ) u_enc (
      .nib_i   (cur_nib),
      .ascii_o (digit_asc)
   );

   assign out_valid_o = (state_q != FMT_IDLE);
   assign busy_o      = (state_q != FMT_IDLE);
   assign accept      = out_valid_o && out_ready_i;
   assign launch      = (state_q == FMT_IDLE) && start_i;
   assign done_o      = done_q;

   always_comb begin
      unique case (state_q)
         FMT_PFX1:  out_data_o = ASC_X;
         FMT_DIGIT: out_data_o = digit_asc;
         default:   out_data_o = ASC_ZERO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FMT_IDLE;
         val_q   <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            FMT_IDLE: begin
               if (launch) begin
                  val_q   <= value_i;
                  idx_q   <= lead_idx;
                  state_q <= lead_nz ? FMT_PFX0 : FMT_ZERO;
               end
            end
            FMT_ZERO: begin
               if (accept) begin
                  state_q <= FMT_IDLE;
                  done_q  <= 1'b1;
               end
            end
            FMT_PFX0: begin
               if (accept) state_q <= FMT_PFX1;
            end
            FMT_PFX1: begin
               if (accept) state_q <= FMT_DIGIT;
            end
            FMT_DIGIT: begin
               if (accept) begin
                  if (idx_q == '0) begin
                     state_q <= FMT_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q - 1'b1;
                  end
               end
            end
            default: state_q <= FMT_IDLE;
         endcase
      end
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o))
      else $error("character changed while stalled");

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done held longer than one cycle");

   assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(out_valid_o && out_ready_i))
      else $error("done without a preceding accept");

   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(val_q))
      else $error("start while busy disturbed the held value");

   assert_first_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> out_valid_o)
      else $error("no character after start");

endmodule

// File: tb/test_hexfmt_stream.sv
module test_hexfmt_stream;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        start_w = 1'b0, start_n = 1'b0;
   logic [31:0] val_w = '0;
   logic [11:0] val_n = '0;
   logic        rdy_w = 1'b0, rdy_n = 1'b0;
   logic        busy_w, busy_n, valid_w, valid_n, done_w, done_n;
   logic [7:0]  data_w, data_n;

   hexfmt_stream i_hexfmt_stream (
      .clk(clk), .rst_n(rst_n), .start_i(start_w), .value_i(val_w),
      .busy_o(busy_w), .out_valid_o(valid_w), .out_ready_i(rdy_w),
      .out_data_o(data_w), .done_o(done_w));

   hexfmt_stream #(.VAL_W(12)) i_hexfmt_stream_w12 (
      .clk(clk), .rst_n(rst_n), .start_i(start_n), .value_i(val_n),
      .busy_o(busy_n), .out_valid_o(valid_n), .out_ready_i(rdy_n),
      .out_data_o(data_n), .done_o(done_n));

   bit sel = 1'b0;
   logic       m_busy, m_valid, m_done;
   logic [7:0] m_data;
   assign m_busy  = sel ? busy_n  : busy_w;
   assign m_valid = sel ? valid_n : valid_w;
   assign m_done  = sel ? done_n  : done_w;
   assign m_data  = sel ? data_n  : data_w;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit [15:0] lfsr = 16'hACE1;
   byte unsigned exp_c [12];
   int exp_len;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic build_expected(input logic [31:0] v);
      int top = 0;
      if (v == 0) begin
         exp_c[0] = 8'h30;
         exp_len  = 1;
      end else begin
         exp_c[0] = 8'h30;
         exp_c[1] = 8'h78;
         exp_len  = 2;
         for (int k = 7; k >= 0; k--) begin
            if (((v >> (4*k)) & 32'hF) != 0 && top == 0) top = k + 1;
         end
         for (int k = top - 1; k >= 0; k--) begin
            int d = int'((v >> (4*k)) & 32'hF);
            exp_c[exp_len] = byte'((d < 10) ? (48 + d) : (65 + d - 10));
            exp_len++;
         end
      end
   endtask

   task automatic run_one(input bit nar, input logic [31:0] v, input bit inject);
      int got = 0;
      int guard = 0;
      bit stall = 1'b0;
      bit injected = 1'b0;
      bit rdy;
      logic [7:0] pdata = '0;
      string tag;
      build_expected(v);
      @(negedge clk);
      sel = nar;
      if (nar) begin start_n = 1'b1; val_n = v[11:0]; end
      else     begin start_w = 1'b1; val_w = v; end
      @(negedge clk);
      start_n = 1'b0; start_w = 1'b0;
      chk(m_valid == 1'b1, "R9 valid after start", int'(m_valid), 1);
      while (got < exp_len && guard < 400) begin
         if (stall) chk(m_valid && m_data == pdata, "R5 hold", int'(m_data), int'(pdata));
         chk(!m_done, "R7 early done", int'(m_done), 0);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rdy = lfsr[0] | lfsr[3];
         rdy_n = nar & rdy;
         rdy_w = !nar & rdy;
         start_n = 1'b0; start_w = 1'b0;
         if (m_valid && rdy) begin
            if (v == 0)        tag = "R1 zero text";
            else if (got < 2)  tag = "R2 prefix";
            else if (got == 2) tag = "R3 leading digit";
            else               tag = "R4 digit";
            if (nar) tag = {tag, " R10"};
            chk(m_data == exp_c[got], tag, int'(m_data), int'(exp_c[got]));
            got++;
         end
         stall = m_valid && !rdy;
         pdata = m_data;
         if (inject && !injected && got == 1 && got < exp_len) begin
            chk(m_busy == 1'b1, "R6 busy at injection", int'(m_busy), 1);
            if (nar) begin start_n = 1'b1; val_n = ~v[11:0]; end
            else     begin start_w = 1'b1; val_w = ~v; end
            injected = 1'b1;
         end
         @(negedge clk);
         guard++;
      end
      rdy_n = 1'b0; rdy_w = 1'b0; start_n = 1'b0; start_w = 1'b0;
      chk(guard < 400, "R5 stream stalled", guard, 400);
      chk(m_done == 1'b1, "R7 done after last accept", int'(m_done), 1);
      @(negedge clk);
      chk(m_done == 1'b0, "R7 done one cycle", int'(m_done), 0);
      chk(m_busy == 1'b0, "R6 no extra conversion", int'(m_busy), 0);
   endtask

   initial begin
      #5;
      chk(!valid_w && !busy_w && !done_w, "R8 reset quiet", int'({valid_w, busy_w, done_w}), 0);
      repeat (3) @(negedge clk);
      chk(!valid_n && !busy_n && !done_n, "R8 reset quiet w12", int'({valid_n, busy_n, done_n}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid_w && !busy_w && !done_w, "R8 after reset", int'({valid_w, busy_w, done_w}), 0);

      run_one(1'b0, 32'h0, 1'b0);
      run_one(1'b0, 32'hFFFF_FFFF, 1'b0);
      run_one(1'b0, 32'h8000_0000, 1'b0);
      run_one(1'b0, 32'h0001_0000, 1'b0);
      run_one(1'b0, 32'h0000_000F, 1'b0);
      run_one(1'b0, 32'hABCD_EF01, 1'b1);
      run_one(1'b0, 32'h00A0_0B00, 1'b1);
      run_one(1'b0, 32'h1234_5678, 1'b0);
      for (int b = 0; b < 32; b++) run_one(1'b0, 32'h1 << b, b[0]);

      for (int n = 0; n < 4096; n++) run_one(1'b1, 32'(n), (n % 7) == 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule